// File: doc/BRIEF.md
# Instruction Fetch Fault Checker

This block screens every instruction fetch address before it reaches the fetch path. It takes a 32-bit fetch address, whose natural granule is 4 bytes, together with a RAM-enable control bit and a 2-bit variant select. It returns the corrected fetch address and three fault flags: misaligned, fetch access error and fetch access exception. The three checking variants differ in how they treat a misaligned address and in which address windows of the high device region they fault. A fourth select value turns all checking off.

The request and result sides are valid/ready streams with a single register stage between them. A fetch is accepted when `in_valid` and `in_ready` are both high on a clock edge. Its result is then presented on `out_valid` from the next cycle onward. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so back-pressure on `out_ready` stalls the input at once and drops no result. While `out_valid` is high and `out_ready` is low, the result must not change. `ram_en` and `variant` are plain control pins. They are sampled together with the address on acceptance.

Top module: `fetch_guard`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1. `in_ready` equals `!out_valid || out_ready`. A fetch accepted at a clock edge shows its result with `out_valid`=1 right after that edge. A result that is held with `out_ready`=0 keeps every output field stable.
- R2: With variant 0, an address whose two low bits are not 00 sets `out_misalign`. The address has its two low bits cleared before any window check, and `out_addr` carries this cleared address.
- R3: With variant 0, an aligned address in 0xFE800000..0xFEFEFFFF or in 0xFEFF0600..0xFEFF7FFF sets `out_err`. Addresses in 0xFEFF0000..0xFEFF05FF and 0xFEFF8000..0xFEFFFFFF do not.
- R4: With variant 0, an address in 0xFE004000..0xFE7FFFFF sets `out_exc`. An address in 0xFE000000..0xFE003FFF sets `out_exc` only when `ram_en` is 0.
- R5: With variant 1, a misaligned address sets `out_err` (not `out_misalign`), and `out_addr` has its low two bits cleared. An aligned address in 0xFE800000..0xFEFFFFFF also sets `out_err`. Variant 1 never sets `out_exc` or `out_misalign`.
- R6: With variant 2, the low two bits are cleared silently, so `out_misalign` stays 0. An address in 0xFE800000..0xFEFFFFFF sets `out_err`.
- R7: With variant 2, an address in 0xFE008000..0xFE7FFFFF sets `out_exc`. An address in 0xFE000000..0xFE007FFF sets `out_exc` only when `ram_en` is 0.
- R8: `out_err` and `out_exc` are never both 1. When the error and exception rules both apply, only `out_err` is raised.
- R9: With variant 3, `out_addr` equals the input address unchanged, and all three flags are 0.
- R10: Addresses outside every window listed for the selected variant raise no flag other than the misalignment handling of that variant. In particular, `ram_en` has no effect outside the low boot window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Fetch request present |
| in_ready | output | 1 | Request can be accepted this cycle |
| in_addr | input | 32 | Fetch address |
| ram_en | input | 1 | Boot RAM enabled; clear makes the low boot window fault |
| variant | input | 2 | Checking variant: 0, 1, 2, or 3 = no checks |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_addr | output | 32 | Corrected fetch address |
| out_misalign | output | 1 | Misaligned fetch flag |
| out_err | output | 1 | Fetch access error flag |
| out_exc | output | 1 | Fetch access exception flag |

## Verification
Every result is due exactly one clock edge after the edge that accepts its fetch. The one register stage is the only storage on the path. The bench drives each request half a cycle before an edge, lets that edge accept it, and reads all four result fields at the following falling edge. It never reads them at the edge where they change. In the stall scenario the bench keeps `out_ready` low for several cycles and reads the result at each falling edge. This shows that the result stays frozen and that `in_ready` stays low. It then releases `out_ready` and expects the waiting request to appear one edge later.

// File: rtl/fg_pkg.sv
package fg_pkg;

  localparam int FG_AW      = 32;
  localparam int FG_GRAN_LG = 2;

  typedef enum logic [1:0] {
    FG_V_SPLIT   = 2'd0,
    FG_V_STRICT  = 2'd1,
    FG_V_LENIENT = 2'd2,
    FG_V_OFF     = 2'd3
  } fg_var_e;

  typedef struct packed {
    logic [FG_AW-1:0] addr;
    logic             mis;
    logic             err;
    logic             exc;
  } fg_res_t;

  // window table indices
  localparam int WI_SPLIT_ERR_LO  = 0;
  localparam int WI_SPLIT_ERR_HI  = 1;
  localparam int WI_SPLIT_EXC     = 2;
  localparam int WI_SPLIT_BOOT    = 3;
  localparam int WI_WIDE_ERR      = 4;
  localparam int WI_LEN_EXC       = 5;
  localparam int WI_LEN_BOOT      = 6;
  localparam int FG_NWIN          = 7;

  function automatic logic [FG_AW-1:0] fg_win_lo(input int idx);
    case (idx)
      WI_SPLIT_ERR_LO: return 32'hFE80_0000;
      WI_SPLIT_ERR_HI: return 32'hFEFF_0600;
      WI_SPLIT_EXC:    return 32'hFE00_4000;
      WI_SPLIT_BOOT:   return 32'hFE00_0000;
      WI_WIDE_ERR:     return 32'hFE80_0000;
      WI_LEN_EXC:      return 32'hFE00_8000;
      default:         return 32'hFE00_0000;
    endcase
  endfunction

  function automatic logic [FG_AW-1:0] fg_win_hi(input int idx);
    case (idx)
      WI_SPLIT_ERR_LO: return 32'hFEFE_FFFF;
      WI_SPLIT_ERR_HI: return 32'hFEFF_7FFF;
      WI_SPLIT_EXC:    return 32'hFE7F_FFFF;
      WI_SPLIT_BOOT:   return 32'hFE00_3FFF;
      WI_WIDE_ERR:     return 32'hFEFF_FFFF;
      WI_LEN_EXC:      return 32'hFE7F_FFFF;
      default:         return 32'hFE00_7FFF;
    endcase
  endfunction

endpackage

// File: rtl/fg_align.sv
module fg_align
  import fg_pkg::*;
#(
  parameter int AW      = FG_AW,
  parameter int GRAN_LG = FG_GRAN_LG
) (
  input  logic [AW-1:0] addr_i,
  input  fg_var_e       var_i,
  output logic [AW-1:0] addr_o,
  output logic          mis_o
);
  localparam logic [AW-1:0] LOW_MASK = AW'((1 << GRAN_LG) - 1);

  logic [AW-1:0] cleared;

  always_comb begin
    mis_o   = |(addr_i & LOW_MASK);
    cleared = addr_i & ~LOW_MASK;
    addr_o  = (var_i == FG_V_OFF) ? addr_i : cleared;
  end
endmodule

// File: rtl/fg_classify.sv
module fg_classify
  import fg_pkg::*;
#(
  parameter int AW   = FG_AW,
  parameter int NWIN = FG_NWIN
) (
  input  logic [AW-1:0] addr_i,
  input  logic          mis_i,
  input  logic          ram_en_i,
  input  fg_var_e       var_i,
  output logic          mis_o,
  output logic          err_o,
  output logic          exc_o
);
  logic [NWIN-1:0] hit;

  for (genvar gi = 0; gi < NWIN; gi++) begin : g_win
    localparam logic [AW-1:0] LO = fg_win_lo(gi);
    localparam logic [AW-1:0] HI = fg_win_hi(gi);
    assign hit[gi] = (addr_i >= LO) && (addr_i <= HI);
  end

  logic err_raw, exc_raw;

  always_comb begin
    mis_o   = 1'b0;
    err_raw = 1'b0;
    exc_raw = 1'b0;
    unique case (var_i)
      FG_V_SPLIT: begin
        mis_o   = mis_i;
        err_raw = hit[WI_SPLIT_ERR_LO] | hit[WI_SPLIT_ERR_HI];
        exc_raw = hit[WI_SPLIT_EXC] | (hit[WI_SPLIT_BOOT] & ~ram_en_i);
      end
      FG_V_STRICT: begin
        err_raw = mis_i | hit[WI_WIDE_ERR];
      end
      FG_V_LENIENT: begin
        err_raw = hit[WI_WIDE_ERR];
        exc_raw = hit[WI_LEN_EXC] | (hit[WI_LEN_BOOT] & ~ram_en_i);
      end
      default: ;
    endcase
    // error outranks exception
    err_o = err_raw;
    exc_o = exc_raw & ~err_raw;
  end
endmodule

// File: rtl/fg_stage.sv
module fg_stage
  import fg_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    in_valid,
  output logic    in_ready,
  input  fg_res_t in_res,
  output logic    out_valid,
  input  logic    out_ready,
  output fg_res_t out_res
);
  logic take;

  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_res   <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_res   <= in_res;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R1
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_res)); // R1
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R1
endmodule

// File: rtl/fetch_guard.sv
module fetch_guard
  import fg_pkg::*;
#(
  parameter int AW      = FG_AW,
  parameter int GRAN_LG = FG_GRAN_LG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] in_addr,
  input  logic          ram_en,
  input  logic [1:0]    variant,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_addr,
  output logic          out_misalign,
  output logic          out_err,
  output logic          out_exc
);
  fg_var_e       var_sel;
  logic [AW-1:0] adj_addr;
  logic          raw_mis;
  fg_res_t       nxt, cur;

  assign var_sel = fg_var_e'(variant);

  fg_align #(.AW(AW), .GRAN_LG(GRAN_LG)) u_align (
    .addr_i (in_addr),
    .var_i  (var_sel),
    .addr_o (adj_addr),
    .mis_o  (raw_mis)
  );

  fg_classify #(.AW(AW)) u_class (
    .addr_i   (adj_addr),
    .mis_i    (raw_mis),
    .ram_en_i (ram_en),
    .var_i    (var_sel),
    .mis_o    (nxt.mis),
    .err_o    (nxt.err),
    .exc_o    (nxt.exc)
  );

  assign nxt.addr = adj_addr;

  fg_stage u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_res    (nxt),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_res   (cur)
  );

  assign out_addr     = cur.addr;
  assign out_misalign = cur.mis;
  assign out_err      = cur.err;
  assign out_exc      = cur.exc;

  AST_ONE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_err && out_exc)); // R8
  AST_MIS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_misalign |-> out_addr[GRAN_LG-1:0] == '0); // R2
  AST_ODD_ONLY_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_addr[GRAN_LG-1:0] != '0) |-> !out_misalign && !out_err && !out_exc); // R9
endmodule

// File: tb/test_fetch_guard.sv
module test_fetch_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_addr = '0;
  logic        ram_en = 1'b0;
  logic [1:0]  variant = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_addr;
  logic        out_misalign, out_err, out_exc;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  fetch_guard i_fetch_guard (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .ram_en(ram_en), .variant(variant),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_misalign(out_misalign), .out_err(out_err), .out_exc(out_exc)
  );

  function automatic bit inw(input logic [31:0] a, input logic [31:0] lo, input logic [31:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  // expected {addr, misalign, err, exc} from the requirements
  function automatic logic [34:0] expect_of(input logic [31:0] a, input logic r, input logic [1:0] v);
    logic [31:0] al;
    logic m, e, x;
    al = {a[31:2], 2'b00};
    m  = |a[1:0];
    e  = 1'b0;
    x  = 1'b0;
    case (v)
      2'd0: begin
        e = inw(al, 32'hFE800000, 32'hFEFEFFFF) || inw(al, 32'hFEFF0600, 32'hFEFF7FFF);
        if (!e) x = inw(al, 32'hFE004000, 32'hFE7FFFFF) || (!r && inw(al, 32'hFE000000, 32'hFE003FFF));
        return {al, m, e, x};
      end
      2'd1: begin
        e = m || inw(al, 32'hFE800000, 32'hFEFFFFFF);
        return {al, 1'b0, e, 1'b0};
      end
      2'd2: begin
        e = inw(al, 32'hFE800000, 32'hFEFFFFFF);
        if (!e) x = inw(al, 32'hFE008000, 32'hFE7FFFFF) || (!r && inw(al, 32'hFE000000, 32'hFE007FFF));
        return {al, 1'b0, e, x};
      end
      default: return {a, 3'b000};
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // one request, result sampled at the falling edge after acceptance
  task automatic fetch(input string tag, input logic [31:0] a, input logic r, input logic [1:0] v);
    @(negedge clk);
    in_addr = a; ram_en = r; variant = v; in_valid = 1'b1; out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(tag, {29'd0, out_valid, out_addr, out_misalign, out_err, out_exc},
               {29'd0, 1'b1, expect_of(a, r, v)});
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 reset valid", {63'd0, out_valid}, 64'd0);
    check("R1 reset ready", {63'd0, in_ready}, 64'd1);
  endtask

  task automatic t_split;
    fetch("R2 mis plain", 32'h0000_1003, 1'b1, 2'd0);
    fetch("R2 mis in err", 32'hFE80_0001, 1'b1, 2'd0);
    fetch("R3 err low edge", 32'hFE80_0000, 1'b1, 2'd0);
    fetch("R3 err high win", 32'hFEFF_0600, 1'b1, 2'd0);
    fetch("R3 gap below", 32'hFEFF_05FC, 1'b1, 2'd0);
    fetch("R3 gap above", 32'hFEFF_8000, 1'b1, 2'd0);
    fetch("R4 exc", 32'hFE00_4000, 1'b1, 2'd0);
    fetch("R4 boot ram on", 32'hFE00_3FFC, 1'b1, 2'd0);
    fetch("R4 boot ram off", 32'hFE00_3FFC, 1'b0, 2'd0);
    fetch("R8 top of exc", 32'hFE7F_FFFC, 1'b0, 2'd0);
  endtask

  task automatic t_strict;
    fetch("R5 mis err", 32'h0000_2002, 1'b1, 2'd1);
    fetch("R5 window err", 32'hFEFF_FFFC, 1'b1, 2'd1);
    fetch("R5 no exc", 32'hFE00_4000, 1'b0, 2'd1);
  endtask

  task automatic t_lenient;
    fetch("R6 silent align", 32'h1234_5677, 1'b1, 2'd2);
    fetch("R6 err", 32'hFEFF_0004, 1'b1, 2'd2);
    fetch("R7 exc", 32'hFE00_8000, 1'b1, 2'd2);
    fetch("R7 boot ram on", 32'hFE00_7FFC, 1'b1, 2'd2);
    fetch("R7 boot ram off", 32'hFE00_4001, 1'b0, 2'd2);
  endtask

  task automatic t_misc;
    fetch("R9 bypass", 32'hFE80_0003, 1'b0, 2'd3);
    fetch("R10 outside ram off", 32'hFDFF_FFFC, 1'b0, 2'd0);
    fetch("R10 outside v2", 32'hFF00_0000, 1'b0, 2'd2);
  endtask

  task automatic t_stall;
    logic [34:0] ea, eb;
    ea = expect_of(32'hFE80_0010, 1'b1, 2'd2);
    eb = expect_of(32'hFE00_0000, 1'b0, 2'd0);
    @(negedge clk);
    out_ready = 1'b0;
    in_addr = 32'hFE80_0010; ram_en = 1'b1; variant = 2'd2; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_addr = 32'hFE00_0000; ram_en = 1'b0; variant = 2'd0;
    for (int k = 0; k < 3; k++) begin
      check("R1 stall hold", {28'd0, in_ready, out_valid, out_addr, out_misalign, out_err, out_exc},
                             {28'd0, 1'b0, 1'b1, ea});
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 stall release", {29'd0, out_valid, out_addr, out_misalign, out_err, out_exc},
                              {29'd0, 1'b1, eb});
    @(negedge clk);
    check("R1 drained", {63'd0, out_valid}, 64'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset;
    @(negedge clk);
    rst_n = 1'b1;
    t_split;
    t_strict;
    t_lenient;
    t_misc;
    t_stall;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule